// File: doc/BRIEF.md
# Multiplexed Parallel Host Bus Port

This block lets an external processor reach an internal byte-addressed register space over an 8-bit bus that carries first an address byte and then a data byte. A strap input picks the bus protocol. In one protocol the host uses separate active-low read and write strobes. In the other it uses one active-high enable strobe plus a direction line. Every host input is asynchronous to the internal clock. The block passes each one through a two-flop synchronizer and finds its edges in the internal clock domain. It samples the bus through a matching pipeline, so each bus sample lines up with the strobe sample it belongs to.

The address byte is taken when the address-latch input falls. The full internal address joins a page register, as the upper part, with that byte, as the lower part. The page register itself answers at byte offset 0x7C of every page, so the host can always switch pages. All other accesses go to the register file through a request/acknowledge handshake that carries one byte. The ready output drops while a transfer is outstanding and during a fixed recovery interval after each access, so a host that polls it never overruns the port.

Top module: `mux_host_port`

## Requirements
- R1: The strap value `mode_sel` selects the protocol. When it is 0, `host_rd_e` is an active-low read strobe and `host_wr_rw` is an active-low write strobe. When it is 1, `host_rd_e` is an active-high enable and `host_wr_rw` gives the direction, with 1 for read and 0 for write.
- R2: The address byte is the value that was on `ad_in` while `host_ale` was still high, just before it fell. The bus may change to data at the same moment as the fall.
- R3: A write is committed when the write strobe ends (write strobe rising in mode 0, enable falling with direction 0 in mode 1). It issues one request with `reg_we`=1, with `reg_addr` = {page, address byte} and `reg_wdata` = the last bus value seen while the strobe was active. The request holds steady until `reg_ack`, and it is released on the cycle after `reg_ack`.
- R4: Address byte 0x7C reaches the page register in any page. A write there loads the page register and raises no request. A read there returns the page value. The page register resets to 0.
- R5: A read starts at the leading edge of the read strobe. It requests the byte at {page, address byte}. The byte returned with `reg_ack` is presented on `ad_out`.
- R6: `ad_oe` is high only while `host_cs_n` is low and the read strobe is active. It is low after reset.
- R7: When `host_cs_n` is high during a strobe, the access is ignored. No request is made and the page register keeps its value.
- R8: `rdy` is high after reset. It is low while a request is outstanding. After a write is committed, it stays low for exactly WR_GAP cycles (default 10). After a read starts, it stays low for exactly RD_GAP cycles (default 8).
- R9: `mode_sel` is sampled only while reset is asserted. Changing it later does not change the protocol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset; the strap is sampled while it is low |
| mode_sel | input | 1 | Protocol strap |
| host_cs_n | input | 1 | Active-low chip select |
| host_ale | input | 1 | Address latch / address strobe, active high |
| host_rd_e | input | 1 | Read strobe (mode 0) or enable (mode 1) |
| host_wr_rw | input | 1 | Write strobe (mode 0) or read/write direction (mode 1) |
| ad_in | input | 8 | Bus value seen by the pads |
| ad_out | output | 8 | Read data for the bus |
| ad_oe | output | 1 | Bus output enable |
| rdy | output | 1 | Ready for the next access |
| reg_req | output | 1 | Register-file request |
| reg_we | output | 1 | Request is a write |
| reg_addr | output | PAGE_W+8 | Register-file byte address |
| reg_wdata | output | 8 | Write data |
| reg_rdata | input | 8 | Read data from the register file |
| reg_ack | input | 1 | Request completed |

## Verification
The assertions watch the handshake on every cycle. A request keeps its address, direction and data until it is acknowledged, and it drops right after the acknowledge. No request ever targets the page-register offset. `rdy` stays low while a request is outstanding. The latched strap never moves outside reset. Only directed scenarios can show the rest: which protocol is in force, that address and data come from the right bus sample, the exact length of each recovery window, the page values returned, and that deselected accesses leave no trace.

// File: rtl/mux_host_port.sv
module mux_host_port #(
  parameter int PAGE_W = 8,
  parameter int WR_GAP = 10,
  parameter int RD_GAP = 8,
  parameter logic [7:0] PAGE_OFS = 8'h7C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_sel,
  input  logic              host_cs_n,
  input  logic              host_ale,
  input  logic              host_rd_e,
  input  logic              host_wr_rw,
  input  logic [7:0]        ad_in,
  output logic [7:0]        ad_out,
  output logic              ad_oe,
  output logic              rdy,
  output logic              reg_req,
  output logic              reg_we,
  output logic [PAGE_W+7:0] reg_addr,
  output logic [7:0]        reg_wdata,
  input  logic [7:0]        reg_rdata,
  input  logic              reg_ack
);
  localparam int GMAX = (WR_GAP > RD_GAP) ? WR_GAP : RD_GAP;
  localparam int GW   = $clog2(GMAX + 1) + 1;

  logic              mode_q;
  logic [2:0]        cs_p, ale_p, sa_p, sb_p;
  logic [7:0]        ad_p1, ad_p2, ad_p3;
  logic [7:0]        addr_q, rd_q;
  logic [PAGE_W-1:0] page_q;
  logic [GW-1:0]     gap_q;
  logic              rd_now, rd_prev, wr_now, wr_prev;
  logic              ale_fall, wr_end, rd_start, hit_page;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= mode_sel;
      cs_p   <= '1;
      ale_p  <= '0;
      sa_p   <= {3{~mode_sel}};
      sb_p   <= '1;
      ad_p1  <= '0;
      ad_p2  <= '0;
      ad_p3  <= '0;
    end else begin
      cs_p  <= {cs_p[1:0], host_cs_n};
      ale_p <= {ale_p[1:0], host_ale};
      sa_p  <= {sa_p[1:0], host_rd_e};
      sb_p  <= {sb_p[1:0], host_wr_rw};
      ad_p1 <= ad_in;
      ad_p2 <= ad_p1;
      ad_p3 <= ad_p2;
    end
  end

  assign rd_now  = mode_q ? (sa_p[1] & sb_p[1])  : ~sa_p[1];
  assign rd_prev = mode_q ? (sa_p[2] & sb_p[2])  : ~sa_p[2];
  assign wr_now  = mode_q ? (sa_p[1] & ~sb_p[1]) : ~sb_p[1];
  assign wr_prev = mode_q ? (sa_p[2] & ~sb_p[2]) : ~sb_p[2];

  assign ale_fall = ale_p[2] & ~ale_p[1];
  assign wr_end   = wr_prev & ~wr_now & ~cs_p[2];
  assign rd_start = rd_now & ~rd_prev & ~cs_p[1];
  assign hit_page = (addr_q == PAGE_OFS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q    <= '0;
      page_q    <= '0;
      rd_q      <= '0;
      gap_q     <= '0;
      reg_req   <= 1'b0;
      reg_we    <= 1'b0;
      reg_wdata <= '0;
    end else begin
      if (ale_fall) addr_q <= ad_p3;
      if (gap_q != '0) gap_q <= gap_q - 1'b1;
      if (reg_req && reg_ack) begin
        reg_req <= 1'b0;
        if (!reg_we) rd_q <= reg_rdata;
      end
      if (wr_end) begin
        gap_q <= GW'(WR_GAP);
        if (hit_page) begin
          page_q <= ad_p3[PAGE_W-1:0];
        end else begin
          reg_req   <= 1'b1;
          reg_we    <= 1'b1;
          reg_wdata <= ad_p3;
        end
      end else if (rd_start) begin
        gap_q <= GW'(RD_GAP);
        if (hit_page) begin
          rd_q <= 8'(page_q);
        end else begin
          reg_req <= 1'b1;
          reg_we  <= 1'b0;
        end
      end
    end
  end

  assign reg_addr = {page_q, addr_q};
  assign rdy      = (gap_q == '0) & ~reg_req;
  assign ad_out   = rd_q;
  assign ad_oe    = rst_n & ~host_cs_n &
                    (mode_q ? (host_rd_e & host_wr_rw) : ~host_rd_e);
endmodule

// File: rtl/host_port_chk.sv
module host_port_chk #(
  parameter int AW = 16,
  parameter logic [7:0] PAGE_OFS = 8'h7C
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rdy,
  input logic          reg_req,
  input logic          reg_ack,
  input logic          reg_we,
  input logic [AW-1:0] reg_addr,
  input logic [7:0]    reg_wdata,
  input logic          mode_q
);
  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req && !reg_ack |=> reg_req && $stable(reg_addr) && $stable(reg_we) && $stable(reg_wdata));

  p_req_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req && reg_ack |=> !reg_req);

  p_page_local_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req |-> reg_addr[7:0] != PAGE_OFS);

  p_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req |-> !rdy);

  p_strap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(mode_q));
endmodule

bind mux_host_port host_port_chk #(.AW(PAGE_W + 8), .PAGE_OFS(PAGE_OFS)) u_chk (
  .clk(clk), .rst_n(rst_n), .rdy(rdy), .reg_req(reg_req), .reg_ack(reg_ack),
  .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .mode_q(mode_q)
);

// File: tb/test_mux_host_port.sv
`timescale 1ns/1ps
module test_mux_host_port;
  localparam int WR_GAP = 10;
  localparam int RD_GAP = 8;

  logic clk = 0, rst_n = 0, mode_sel = 0;
  logic host_cs_n = 1, host_ale = 0, host_rd_e = 1, host_wr_rw = 1;
  logic [7:0] ad_in = 0, ad_out, reg_wdata, reg_rdata;
  logic ad_oe, rdy, reg_req, reg_we, reg_ack = 0;
  logic [15:0] reg_addr;

  int errs = 0, checks = 0, wr_cnt = 0, rd_cnt = 0, ack_cnt = 0;
  logic [15:0] last_addr;
  logic [7:0]  last_data;
  bit proto = 0;

  always #2.5 clk = ~clk;

  mux_host_port #(.WR_GAP(WR_GAP), .RD_GAP(RD_GAP)) i_mux_host_port (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .host_cs_n(host_cs_n),
    .host_ale(host_ale), .host_rd_e(host_rd_e), .host_wr_rw(host_wr_rw),
    .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe), .rdy(rdy),
    .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_ack(reg_ack));

  function automatic logic [7:0] model(logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction
  assign reg_rdata = model(reg_addr);

  always @(posedge clk) begin
    reg_ack <= 1'b0;
    if (reg_req && !reg_ack) begin
      if (ack_cnt == 1) begin
        reg_ack <= 1'b1;
        ack_cnt <= 0;
        last_addr <= reg_addr;
        if (reg_we) begin wr_cnt <= wr_cnt + 1; last_data <= reg_wdata; end
        else rd_cnt <= rd_cnt + 1;
      end else ack_cnt <= ack_cnt + 1;
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic idle_lines();
    host_cs_n = 1; host_ale = 0;
    host_rd_e = proto ? 1'b0 : 1'b1;
    host_wr_rw = 1'b1;
  endtask

  task automatic do_reset(bit m);
    mode_sel = m; proto = m; rst_n = 0;
    idle_lines();
    cyc(4); rst_n = 1; cyc(3);
  endtask

  task automatic send_addr(logic [7:0] a, bit sel);
    host_cs_n = ~sel; ad_in = a; host_ale = 1; cyc(3);
    host_ale = 0; ad_in = 8'hEE; cyc(3);
  endtask

  task automatic host_write(logic [7:0] a, logic [7:0] d, bit sel, output int low);
    send_addr(a, sel);
    ad_in = d;
    if (proto) begin host_wr_rw = 0; host_rd_e = 1; end else host_wr_rw = 0;
    cyc(4);
    if (proto) host_rd_e = 0; else host_wr_rw = 1;
    ad_in = 8'hC3;
    low = 0;
    for (int i = 0; i < 20; i++) begin cyc(1); if (!rdy) low++; end
    idle_lines();
    cyc(2);
  endtask

  task automatic host_read(logic [7:0] a, bit sel, output logic [7:0] d, output bit oe, output int low);
    send_addr(a, sel);
    if (proto) begin host_wr_rw = 1; host_rd_e = 1; end else host_rd_e = 0;
    low = 0;
    for (int i = 0; i < 16; i++) begin cyc(1); if (!rdy) low++; end
    d = ad_out; oe = ad_oe;
    idle_lines();
    cyc(1);
    chk(ad_oe == 0, "R6 oe after release", ad_oe, 0);
    cyc(2);
  endtask

  task automatic t_reset();
    do_reset(0);
    chk(rdy == 1, "R8 rdy after reset", rdy, 1);
    chk(ad_oe == 0, "R6 oe after reset", ad_oe, 0);
    chk(reg_req == 0, "R3 no request after reset", reg_req, 0);
  endtask

  task automatic t_write_m0();
    int low, w0;
    w0 = wr_cnt;
    host_write(8'h7C, 8'h03, 1, low);
    chk(wr_cnt == w0, "R4 page write raises no request", wr_cnt, w0);
    chk(low == WR_GAP, "R8 write gap", low, WR_GAP);
    host_write(8'h15, 8'hA5, 1, low);
    chk(wr_cnt == w0 + 1, "R3 one write request", wr_cnt, w0 + 1);
    chk(last_addr == 16'h0315, "R2 R3 write address", last_addr, 16'h0315);
    chk(last_data == 8'hA5, "R1 R3 write data", last_data, 8'hA5);
  endtask

  task automatic t_read_m0();
    logic [7:0] d; bit oe; int low;
    host_read(8'h20, 1, d, oe, low);
    chk(d == model(16'h0320), "R5 read data", d, model(16'h0320));
    chk(oe == 1, "R6 oe during read", oe, 1);
    chk(low == RD_GAP, "R8 read gap", low, RD_GAP);
    host_read(8'h7C, 1, d, oe, low);
    chk(d == 8'h03, "R4 page readback", d, 8'h03);
  endtask

  task automatic t_cs_ignore();
    logic [7:0] d; bit oe; int low, w0, r0;
    w0 = wr_cnt; r0 = rd_cnt;
    host_write(8'h7C, 8'h09, 0, low);
    host_write(8'h40, 8'h77, 0, low);
    chk(wr_cnt == w0, "R7 deselected write ignored", wr_cnt, w0);
    host_read(8'h41, 0, d, oe, low);
    chk(oe == 0, "R6 no drive without select", oe, 0);
    chk(rd_cnt == r0, "R7 deselected read ignored", rd_cnt, r0);
    host_read(8'h7C, 1, d, oe, low);
    chk(d == 8'h03, "R7 page kept", d, 8'h03);
  endtask

  task automatic t_mode1();
    logic [7:0] d; bit oe; int low;
    do_reset(1);
    host_read(8'h7C, 1, d, oe, low);
    chk(d == 8'h00, "R4 page reset value", d, 0);
    host_write(8'h7C, 8'h11, 1, low);
    host_write(8'h33, 8'h5C, 1, low);
    chk(last_addr == 16'h1133, "R1 mode1 write address", last_addr, 16'h1133);
    chk(last_data == 8'h5C, "R1 mode1 write data", last_data, 8'h5C);
    host_read(8'h44, 1, d, oe, low);
    chk(d == model(16'h1144), "R1 R5 mode1 read", d, model(16'h1144));
    chk(oe == 1, "R6 mode1 oe", oe, 1);
  endtask

  task automatic t_strap();
    int low;
    mode_sel = 0;
    cyc(2);
    host_write(8'h35, 8'h6B, 1, low);
    chk(last_addr == 16'h1135, "R9 strap held address", last_addr, 16'h1135);
    chk(last_data == 8'h6B, "R9 strap held data", last_data, 8'h6B);
  endtask

  initial begin
    t_reset();
    t_write_m0();
    t_read_m0();
    t_cs_ignore();
    t_mode1();
    t_strap();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #400000;
    errs++; checks++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule